// File: doc/BRIEF.md
# Two-Phase Cascaded Display Frame Loader

This block takes a parallel display frame and moves it bit by bit into a chain of cascaded high-voltage driver shift registers, then fires one latch pulse. All registers share one serial data line into the head of the chain. Registers at chain positions 0, 2, 4, ... (counting from the head, 0-based) shift on the falling edge of phase A. Registers at positions 1, 3, ... shift on the falling edge of phase B. In every shift step phase B falls first and phase A falls a programmable gap later. Every odd register therefore captures its upstream neighbour's value before that neighbour moves. This holds even if the neighbour's output switches with zero delay.

The edge order has a side effect at each hop from an odd register into the next even one. There, the downstream register captures the value its neighbour has only just taken in. The last output of that odd register and the first output of the following register therefore always end up equal. The loader accounts for this. It skips the frame bit at each such tie position, and it sends exactly as many shift steps as there are independent positions.

All timing is set in system-clock cycles: phase high time, phase-A low time, the B-to-A fall spacing and the latch width. One parameter set serves a 128-bit chain of four 32-bit registers with 120 display bits. Another serves a single 32-bit register with 30 display bits. A load takes a few thousand cycles, well inside a 10 ms refresh slot.

Top module: `cascade_frame_loader`

## Requirements
- R1: Out of reset and whenever not busy, both phase outputs are high, serial data is low, and latch and done are low.
- R2: A start request is accepted only while busy is low. A start, with any frame value, given during a load has no effect on that load or on the latched result.
- R3: In every shift step phase B falls first. Phase A falls exactly T_GAP cycles after phase B, while phase B is still low.
- R4: Phase A stays low for exactly T_LOW cycles per step. Before each phase-B fall, both phases have been high for at least T_HIGH cycles.
- R5: Serial data changes only in cycles where both phases are high. It is therefore stable from at least T_HIGH+T_GAP cycles before each phase-A fall until the phases rise again.
- R6: Output index j of the chain means register j / REG_BITS (0 = head), stage j % REG_BITS. Index FRAME_BITS-1 is the far end of the last register. Bits are sent highest index first. A load makes exactly FRAME_BITS − floor((NREGS−1)/2) phase-A falls. After the latch, every non-tie output equals the frame bit of the same index.
- R7: A tie position is stage REG_BITS−1 of a register with an odd index r, when r < NREGS−1. Its frame bit is ignored. After the latch, its output equals the frame bit at index j+1.
- R8: Frame bits with index ≥ USED_BITS are replaced by zero before shifting, whatever value arrives on the frame input.
- R9: Latch goes high exactly once per load, after the last shift step. It stays high for exactly T_LATCH cycles, and only while both phases are high.
- R10: Busy rises in the cycle after the start is accepted. It falls in the same cycle latch falls, and done pulses high for exactly that one cycle.
- R11: From start acceptance to done takes exactly 1 + N·(T_HIGH+T_GAP+T_LOW) + T_HIGH + T_LATCH cycles, where N is the step count of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load request, honoured only while idle |
| frame_i | input | FRAME_BITS | Parallel frame, sampled when start is accepted |
| busy_o | output | 1 | High while a load is running |
| done_o | output | 1 | One-cycle pulse when a load completes |
| sdata_o | output | 1 | Shared serial data into the head register |
| clka_o | output | 1 | Phase A shift clock (even chain positions) |
| clkb_o | output | 1 | Phase B shift clock (odd chain positions) |
| latch_o | output | 1 | Latch-enable pulse to all registers |

## Verification
The bench drives the outputs into a behavioural chain in which each register shifts on the falling edge of its own phase. It compares the latched contents with the masked frame. A loader that sent the tie bit, or skipped no positions, would leave the far registers off by one place. Frames with only bit 63 or only bit 64 set catch this, as do frames of all ones, where unused bits must come back zero. A monitor measures every phase-B-to-A spacing, low time, data change and latch width, so an edge order that was reversed or a count that was off by one shows up as a timing violation. A start pulsed with an inverted frame in the middle of a load must leave the result unchanged. The exact start-to-done cycle count catches any state that lasts one cycle too long.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_BFALL,
    ST_AFALL,
    ST_REST,
    ST_LATCH
  } cfl_state_e;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Last stage of an odd-indexed register that feeds a further register:
  // its value always equals the next register's first stage.
  function automatic bit is_tie(int pos, int reg_bits, int nregs);
    int r;
    r = pos / reg_bits;
    return ((pos % reg_bits) == reg_bits - 1) && ((r % 2) == 1) && (r < nregs - 1);
  endfunction

endpackage

// File: rtl/cfl_frame_store.sv
module cfl_frame_store #(
  parameter int FRAME_BITS = 128,
  parameter int USED_BITS  = 120,
  parameter int IDX_W      = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  capture,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic [IDX_W-1:0]      sel_i,
  output logic                  bit_o
);

  logic [FRAME_BITS-1:0] used_mask;
  logic [FRAME_BITS-1:0] frame_q;

  for (genvar j = 0; j < FRAME_BITS; j++) begin : g_mask
    assign used_mask[j] = (j < USED_BITS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
    end else if (capture) begin
      frame_q <= frame_i & used_mask;
    end
  end

  assign bit_o = frame_q[sel_i];

endmodule

// File: rtl/cfl_bit_walker.sv
module cfl_bit_walker #(
  parameter int FRAME_BITS = 128,
  parameter int REG_BITS   = 32,
  parameter int IDX_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             step,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] idx_next_o,
  output logic             last_o
);

  localparam int NREGS = FRAME_BITS / REG_BITS;

  logic [FRAME_BITS-1:0] tie_mask;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      idx_m1;

  for (genvar j = 0; j < FRAME_BITS; j++) begin : g_tie
    assign tie_mask[j] = cfl_pkg::is_tie(j, REG_BITS, NREGS);
  end

  assign idx_m1 = idx_q - IDX_W'(1);

  always_comb begin
    if (idx_q == '0) begin
      idx_next_o = '0;
    end else if (idx_q >= IDX_W'(2) && tie_mask[idx_m1]) begin
      idx_next_o = idx_q - IDX_W'(2);
    end else begin
      idx_next_o = idx_m1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      idx_q <= IDX_W'(FRAME_BITS - 1);
    end else if (step) begin
      idx_q <= idx_next_o;
    end
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == '0);

  // R7: the walker never rests on a tie position
  p_skip_tie_r7: assert property (@(posedge clk) disable iff (rst)
    step |=> !tie_mask[idx_q]);

  // R6: each step moves strictly toward the head of the chain
  p_step_down_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !last_o && !init) |=> (idx_q < $past(idx_q)));

endmodule

// File: rtl/cfl_interval.sv
module cfl_interval #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cascade_frame_loader.sv
module cascade_frame_loader #(
  parameter int FRAME_BITS = 128,
  parameter int REG_BITS   = 32,
  parameter int USED_BITS  = 120,
  parameter int T_HIGH     = 9,
  parameter int T_LOW      = 9,
  parameter int T_GAP      = 20,
  parameter int T_LATCH    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  sdata_o,
  output logic                  clka_o,
  output logic                  clkb_o,
  output logic                  latch_o
);

  import cfl_pkg::*;

  localparam int IDX_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int CNT_W = $clog2(max_of4(T_HIGH, T_LOW, T_GAP, T_LATCH) + 1);

  cfl_state_e       state_q, state_d;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;
  logic             cap_w;
  logic             walk_init;
  logic             walk_step;
  logic [IDX_W-1:0] idx_w;
  logic [IDX_W-1:0] idx_next_w;
  logic [IDX_W-1:0] sel_w;
  logic             last_w;
  logic             bit_w;

  cfl_frame_store #(
    .FRAME_BITS(FRAME_BITS),
    .USED_BITS (USED_BITS),
    .IDX_W     (IDX_W)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .capture(cap_w),
    .frame_i(frame_i),
    .sel_i  (sel_w),
    .bit_o  (bit_w)
  );

  cfl_bit_walker #(
    .FRAME_BITS(FRAME_BITS),
    .REG_BITS  (REG_BITS),
    .IDX_W     (IDX_W)
  ) u_walker (
    .clk       (clk),
    .rst       (rst),
    .init      (walk_init),
    .step      (walk_step),
    .idx_o     (idx_w),
    .idx_next_o(idx_next_w),
    .last_o    (last_w)
  );

  cfl_interval #(
    .CNT_W(CNT_W)
  ) u_interval (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(cnt_val),
    .zero_o  (cnt_zero)
  );

  always_comb begin
    state_d   = state_q;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    cap_w     = 1'b0;
    walk_init = 1'b0;
    walk_step = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_LOAD;
          cap_w     = 1'b1;
          walk_init = 1'b1;
        end
      end
      ST_LOAD: begin
        state_d  = ST_SETUP;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_HIGH - 1);
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          state_d  = ST_BFALL;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(T_GAP - 1);
        end
      end
      ST_BFALL: begin
        if (cnt_zero) begin
          state_d  = ST_AFALL;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(T_LOW - 1);
        end
      end
      ST_AFALL: begin
        if (cnt_zero) begin
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(T_HIGH - 1);
          if (last_w) begin
            state_d = ST_REST;
          end else begin
            state_d   = ST_SETUP;
            walk_step = 1'b1;
          end
        end
      end
      ST_REST: begin
        if (cnt_zero) begin
          state_d  = ST_LATCH;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(T_LATCH - 1);
        end
      end
      ST_LATCH: begin
        if (cnt_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign sel_w = walk_step ? idx_next_w : idx_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      clka_o  <= 1'b1;
      clkb_o  <= 1'b1;
      sdata_o <= 1'b0;
      latch_o <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      clka_o  <= (state_d != ST_AFALL);
      clkb_o  <= !(state_d == ST_BFALL || state_d == ST_AFALL);
      latch_o <= (state_d == ST_LATCH);
      busy_o  <= (state_d != ST_IDLE);
      done_o  <= (state_q == ST_LATCH) && (state_d == ST_IDLE);
      if (state_d == ST_SETUP || state_d == ST_BFALL || state_d == ST_AFALL) begin
        sdata_o <= bit_w;
      end else begin
        sdata_o <= 1'b0;
      end
    end
  end

  // R1: idle output levels
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (clka_o && clkb_o && !latch_o && !sdata_o));

  // R2: the frame is only taken while idle
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    cap_w |-> !busy_o);

  // R3: phase A falls only while phase B is already low
  p_clk_order_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(clka_o) |-> !clkb_o);

  // R3: phase B falls while phase A is high
  p_b_first_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(clkb_o) |-> clka_o);

  // R5: data moves only with both phases high
  p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata_o) |-> (clka_o && clkb_o));

  // R9: latch never overlaps a low phase
  p_latch_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    latch_o |-> (clka_o && clkb_o));

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10: busy ends together with the latch pulse and done
  p_busy_end_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o && $fell(latch_o)));

endmodule

// File: tb/cascade_frame_loader_tb_top.sv
module cfl_tb_mon #(
  parameter int FRAME_BITS = 128,
  parameter int REG_BITS   = 32,
  parameter int T_HIGH     = 9,
  parameter int T_LOW      = 9,
  parameter int T_GAP      = 20,
  parameter int T_LATCH    = 4
) (
  input logic clk,
  input logic rst,
  input logic clka,
  input logic clkb,
  input logic sd,
  input logic le
);
  localparam int NREGS = FRAME_BITS / REG_BITS;

  logic [FRAME_BITS-1:0] chain = '0;
  logic [FRAME_BITS-1:0] shown = '0;
  int falls_a = 0, le_rises = 0;
  int v_gap = 0, v_low = 0, v_high = 0, v_data = 0, v_le = 0;
  int gap = 0, alow = 0, ahigh = 1000, lw = 0;
  logic pa = 1'b1, pb = 1'b1, pd = 1'b0, pl = 1'b0;

  // odd-indexed registers shift on phase B
  always @(negedge clkb) begin
    for (int r = 1; r < NREGS; r += 2) begin
      for (int b = REG_BITS - 1; b > 0; b--) chain[r*REG_BITS+b] = chain[r*REG_BITS+b-1];
      chain[r*REG_BITS] = chain[r*REG_BITS-1];
    end
  end

  // even-indexed registers shift on phase A
  always @(negedge clka) begin
    for (int r = 0; r < NREGS; r += 2) begin
      for (int b = REG_BITS - 1; b > 0; b--) chain[r*REG_BITS+b] = chain[r*REG_BITS+b-1];
      chain[r*REG_BITS] = (r == 0) ? sd : chain[r*REG_BITS-1];
    end
  end

  always @(posedge le) shown = chain;

  always @(negedge clk) begin
    if (!rst) begin
      if (pb && !clkb) gap = 0; else gap = gap + 1;
      if (pa && !clka) begin
        falls_a++;
        if (gap != T_GAP) v_gap++;
        if (clkb) v_gap++;
      end
      if (pa && !clka) alow = 0; else alow = alow + 1;
      if (!pa && clka && alow != T_LOW) v_low++;
      if (!pa && clka) ahigh = 0; else ahigh = ahigh + 1;
      if (pb && !clkb && ahigh < T_HIGH) v_high++;
      if (sd !== pd && !(clka && clkb)) v_data++;
      if (le && !(clka && clkb)) v_le++;
      if (!pl && le) begin le_rises++; lw = 0; end else lw = lw + 1;
      if (pl && !le && lw != T_LATCH) v_le++;
      pa = clka; pb = clkb; pd = sd; pl = le;
    end
  end
endmodule

module cascade_frame_loader_tb_top;
  localparam int TH = 9, TL = 9, TG = 20, TLAT = 4;
  localparam int STEP = TH + TG + TL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_fail = 0;

  logic         start_l = 1'b0, start_s = 1'b0;
  logic [127:0] frame_l = '0;
  logic [31:0]  frame_s = '0;
  logic busy_l, done_l, sd_l, ca_l, cb_l, le_l;
  logic busy_s, done_s, sd_s, ca_s, cb_s, le_s;

  cascade_frame_loader dut_i (
    .clk(clk), .rst(rst), .start_i(start_l), .frame_i(frame_l),
    .busy_o(busy_l), .done_o(done_l), .sdata_o(sd_l),
    .clka_o(ca_l), .clkb_o(cb_l), .latch_o(le_l));

  cascade_frame_loader #(
    .FRAME_BITS(32), .REG_BITS(32), .USED_BITS(30),
    .T_HIGH(TH), .T_LOW(TL), .T_GAP(TG), .T_LATCH(TLAT)
  ) dut_s_i (
    .clk(clk), .rst(rst), .start_i(start_s), .frame_i(frame_s),
    .busy_o(busy_s), .done_o(done_s), .sdata_o(sd_s),
    .clka_o(ca_s), .clkb_o(cb_s), .latch_o(le_s));

  cfl_tb_mon #(.FRAME_BITS(128), .REG_BITS(32), .T_HIGH(TH), .T_LOW(TL), .T_GAP(TG), .T_LATCH(TLAT))
    mon_l (.clk(clk), .rst(rst), .clka(ca_l), .clkb(cb_l), .sd(sd_l), .le(le_l));
  cfl_tb_mon #(.FRAME_BITS(32), .REG_BITS(32), .T_HIGH(TH), .T_LOW(TL), .T_GAP(TG), .T_LATCH(TLAT))
    mon_s (.clk(clk), .rst(rst), .clka(ca_s), .clkb(cb_s), .sd(sd_s), .le(le_s));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_show(logic [127:0] f, int fb, int rb, int ub);
    logic [127:0] m, e;
    int r;
    m = '0;
    for (int j = 0; j < fb; j++) if (j < ub) m[j] = f[j];
    e = m;
    for (int j = 0; j < fb; j++) begin
      r = j / rb;
      if ((j % rb) == rb - 1 && (r % 2) == 1 && r < fb / rb - 1) e[j] = m[j+1];
    end
    return e;
  endfunction

  task automatic run_load(input bit sh, input logic [127:0] f, input bit poke, input string tag);
    int n_exp, lat_exp, fa0, le0, vg0, vl0, vh0, vd0, ve0, t0, k;
    bit fin, busy_ok;
    logic [127:0] exp, got;
    n_exp   = sh ? 32 : 127;
    lat_exp = 1 + n_exp * STEP + TH + TLAT;
    exp     = sh ? exp_show(f, 32, 32, 30) : exp_show(f, 128, 32, 120);
    fa0 = sh ? mon_s.falls_a : mon_l.falls_a;
    le0 = sh ? mon_s.le_rises : mon_l.le_rises;
    vg0 = sh ? mon_s.v_gap : mon_l.v_gap;
    vl0 = sh ? mon_s.v_low + mon_s.v_high : mon_l.v_low + mon_l.v_high;
    vd0 = sh ? mon_s.v_data : mon_l.v_data;
    ve0 = sh ? mon_s.v_le : mon_l.v_le;
    @(negedge clk);
    if (sh) begin frame_s = f[31:0]; start_s = 1'b1; end
    else    begin frame_l = f;       start_l = 1'b1; end
    @(negedge clk);
    start_s = 1'b0; start_l = 1'b0;
    t0 = cyc;
    chk((sh ? busy_s : busy_l) == 1'b1, {"R10 busy after start ", tag}, 128'(sh ? busy_s : busy_l), 128'(1));
    fin = 1'b0; busy_ok = 1'b1; k = 0;
    while (!fin) begin
      @(negedge clk);
      k++;
      if (sh ? done_s : done_l) fin = 1'b1;
      else begin
        if (!(sh ? busy_s : busy_l)) busy_ok = 1'b0;
        if (poke && k == 40) begin
          if (sh) begin frame_s = ~f[31:0]; start_s = 1'b1; end
          else    begin frame_l = ~f;       start_l = 1'b1; end
        end
        if (poke && k == 41) begin start_s = 1'b0; start_l = 1'b0; end
      end
    end
    chk(busy_ok, {"R10 busy held during load ", tag}, 128'(busy_ok), 128'(1));
    chk((cyc - t0) == lat_exp, {"R11 start-to-done cycles ", tag}, 128'(cyc - t0), 128'(lat_exp));
    chk(!(sh ? busy_s : busy_l) && !(sh ? le_s : le_l), {"R10 busy and latch low with done ", tag},
        128'({sh ? busy_s : busy_l, sh ? le_s : le_l}), 128'(0));
    got = sh ? 128'(mon_s.shown) : mon_l.shown;
    chk(got == exp, {"R6 R7 R8 latched contents ", tag}, got, exp);
    chk(((sh ? mon_s.falls_a : mon_l.falls_a) - fa0) == n_exp, {"R6 phase-A fall count ", tag},
        128'((sh ? mon_s.falls_a : mon_l.falls_a) - fa0), 128'(n_exp));
    chk(((sh ? mon_s.le_rises : mon_l.le_rises) - le0) == 1, {"R9 one latch pulse ", tag},
        128'((sh ? mon_s.le_rises : mon_l.le_rises) - le0), 128'(1));
    chk((sh ? mon_s.v_gap : mon_l.v_gap) == vg0, {"R3 B-to-A fall spacing ", tag},
        128'(sh ? mon_s.v_gap : mon_l.v_gap), 128'(vg0));
    chk((sh ? mon_s.v_low + mon_s.v_high : mon_l.v_low + mon_l.v_high) == vl0, {"R4 high/low times ", tag},
        128'(sh ? mon_s.v_low + mon_s.v_high : mon_l.v_low + mon_l.v_high), 128'(vl0));
    chk((sh ? mon_s.v_data : mon_l.v_data) == vd0, {"R5 data stable around edges ", tag},
        128'(sh ? mon_s.v_data : mon_l.v_data), 128'(vd0));
    chk((sh ? mon_s.v_le : mon_l.v_le) == ve0, {"R9 latch width and quiet clocks ", tag},
        128'(sh ? mon_s.v_le : mon_l.v_le), 128'(ve0));
    @(negedge clk);
    chk(!(sh ? done_s : done_l), {"R10 done single cycle ", tag}, 128'(sh ? done_s : done_l), 128'(0));
    chk((sh ? ca_s & cb_s & !sd_s : ca_l & cb_l & !sd_l), {"R1 idle levels after load ", tag},
        128'(sh ? {ca_s, cb_s, sd_s} : {ca_l, cb_l, sd_l}), 128'(3'b110));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] rnd;
    int seed_dummy;
    seed_dummy = $urandom(32'h1F2E3D4C);
    repeat (3) @(negedge clk);
    chk(ca_l && cb_l && !sd_l && !le_l && !busy_l && !done_l, "R1 levels in reset (long)",
        128'({ca_l, cb_l, sd_l, le_l, busy_l, done_l}), 128'(6'b110000));
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(ca_s && cb_s && !sd_s && !le_s && !busy_s && !done_s, "R1 levels after reset (short)",
        128'({ca_s, cb_s, sd_s, le_s, busy_s, done_s}), 128'(6'b110000));

    run_load(1'b0, {128{1'b1}}, 1'b0, "long all ones R8");
    run_load(1'b0, 128'(1) << 63, 1'b0, "long tie bit only r7_");
    run_load(1'b0, 128'(1) << 64, 1'b0, "long bit 64 mirrors R7");
    run_load(1'b0, 128'(1) << 119, 1'b0, "long top used bit R6");
    run_load(1'b0, {32{4'hA}}, 1'b0, "long alternating");
    for (int i = 0; i < 3; i++) begin
      rnd = {$urandom, $urandom, $urandom, $urandom};
      run_load(1'b0, rnd, 1'b0, "long random");
    end
    rnd = {$urandom, $urandom, $urandom, $urandom};
    run_load(1'b0, rnd, 1'b1, "long start ignored R2");

    run_load(1'b1, 128'hFFFF_FFFF, 1'b0, "short all ones R8");
    run_load(1'b1, 128'hC000_0000, 1'b0, "short unused only R8");
    run_load(1'b1, 128'h2000_0001, 1'b0, "short end bits R6");
    for (int i = 0; i < 3; i++) begin
      rnd = 128'($urandom);
      run_load(1'b1, rnd, 1'b0, "short random");
    end
    rnd = 128'($urandom);
    run_load(1'b1, rnd, 1'b1, "short start ignored R2");

    finish_run();
  end
endmodule